// File: doc/BRIEF.md
# Write-Recovery Precharge Guard

This block watches the command stream of a DDR3-style memory controller and tells the scheduler, per bank, whether a PRECHARGE may go out yet after a WRITE. Every WRITE sets a countdown for its bank. The length of that countdown comes from the programmed additive and CAS write latencies, the burst length (full eight-beat or fixed four-beat) and the write recovery time. A bank's flag returns high in the first cycle where a PRECHARGE to that bank is legal.

The guard only tracks timing. It never holds up the command bus, so other commands can go out to any bank while a countdown runs. A PRECHARGE that arrives before its bank is ready is still accepted. The guard reports it with a one-cycle error pulse and the number of the offending bank. Latency settings are captured when each WRITE is issued, so changing them later does not shorten or lengthen a countdown that is already running.

Top module: `wr_pre_guard`

## Requirements
- R1: In the first cycle after reset is released, every bit of `pre_ok` is 1 and `pre_err` is 0.
- R2: Write latency is `cfg_al + cfg_cwl`. With a full-length burst, a WRITE to bank b in cycle T makes cycle T + al + cwl + 4 + twr the first cycle in which a PRECHARGE to b is legal.
- R3: `cfg_burst` = 2'b10 selects fixed four-beat bursts, and the earliest legal cycle becomes T + al + cwl + 2 + twr. The values 2'b00, 2'b01 and 2'b11 all select full-length bursts.
- R4: `pre_ok[b]` is 0 from the cycle after a WRITE to b through the cycle before the earliest legal cycle. It is 1 in the earliest legal cycle and stays 1 until the next WRITE to b.
- R5: A PRECHARGE in a cycle where `pre_ok[cmd_bank]` is 0 makes `pre_err` 1 for exactly the next cycle, with `pre_err_bank` equal to that bank.
- R6: A PRECHARGE to a bank whose `pre_ok` is 1, and any cycle with no PRECHARGE, leaves `pre_err` at 0 in the next cycle.
- R7: A new WRITE to a bank whose countdown is still running makes the later of the two deadlines the one that applies.
- R8: A WRITE to one bank does not change `pre_ok` of any other bank.
- R9: Changing `cfg_al`, `cfg_cwl`, `cfg_twr` or `cfg_burst` after a WRITE does not move that WRITE's deadline.
- R10: A PRECHARGE, whether early or legal, does not change the countdown of any bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | WRITE issued this cycle |
| cmd_pre | input | 1 | PRECHARGE issued this cycle |
| cmd_bank | input | BANK_W | Target bank of the command |
| cfg_al | input | LAT_W | Additive latency, clocks |
| cfg_cwl | input | LAT_W | CAS write latency, clocks |
| cfg_twr | input | TWR_W | Write recovery, clocks |
| cfg_burst | input | 2 | Burst mode; 2'b10 = fixed four-beat |
| pre_ok | output | NUM_BANKS | Per-bank PRECHARGE allowed |
| pre_err | output | 1 | Early PRECHARGE seen in the previous cycle |
| pre_err_bank | output | BANK_W | Bank of the early PRECHARGE |

## Verification
Two things can land in the same cycle: a bank's countdown expiring and a PRECHARGE to that bank. The bench sweeps burst mode, additive latency, CAS write latency and recovery time, and for each setting it issues a PRECHARGE one cycle before the computed deadline and another exactly on it. The first must raise the error and the second must not. A second overlap is a WRITE reload arriving while a countdown is still running. The bench rewrites banks with both longer and shorter requirements and compares every `pre_ok` bit, every cycle, against deadlines it computes arithmetically.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam logic [1:0] BURST_HALF = 2'b10;

  // data clocks after write latency for a given burst mode
  function automatic int unsigned data_clocks(input logic [1:0] mode);
    return (mode == BURST_HALF) ? 2 : 4;
  endfunction
endpackage

// File: rtl/wpg_req_calc.sv
module wpg_req_calc #(
  parameter int LAT_W = 5,
  parameter int TWR_W = 5,
  parameter int CNT_W = 7
) (
  input  logic [LAT_W-1:0] al,
  input  logic [LAT_W-1:0] cwl,
  input  logic [TWR_W-1:0] twr,
  input  logic [1:0]       burst,
  output logic [CNT_W-1:0] load_val
);
  logic [CNT_W-1:0] data_len;

  always_comb begin
    data_len = CNT_W'(wpg_pkg::data_clocks(burst));
    // cycles the counter must still show after the WRITE cycle itself
    load_val = CNT_W'(al) + CNT_W'(cwl) + data_len + CNT_W'(twr) - CNT_W'(1);
  end
endmodule

// File: rtl/wpg_bank_timer.sv
module wpg_bank_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] load_val,
  output logic             pre_ok
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    dec = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
    nxt = (wr_hit && load_val > dec) ? load_val : dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pre_ok <= 1'b1;
    end else begin
      cnt_q  <= nxt;
      pre_ok <= (nxt == '0);
    end
  end

  // R4: a WRITE always closes the window in the next cycle
  a_r4_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !pre_ok);

  // R7: a reload never cuts short the new requirement
  a_r7_keeps_later: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (cnt_q >= $past(load_val)));

  // R10: without a WRITE the count only falls by one
  a_r10_countdown: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/wr_pre_guard.sv
module wr_pre_guard #(
  parameter int NUM_BANKS = 8,
  parameter int LAT_W     = 5,
  parameter int TWR_W     = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = ((LAT_W > TWR_W) ? LAT_W : TWR_W) + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_wr,
  input  logic                 cmd_pre,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [LAT_W-1:0]     cfg_al,
  input  logic [LAT_W-1:0]     cfg_cwl,
  input  logic [TWR_W-1:0]     cfg_twr,
  input  logic [1:0]           cfg_burst,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic                 pre_err,
  output logic [BANK_W-1:0]    pre_err_bank
);
  logic [CNT_W-1:0] load_val;

  wpg_req_calc #(.LAT_W(LAT_W), .TWR_W(TWR_W), .CNT_W(CNT_W)) u_calc (
    .al(cfg_al), .cwl(cfg_cwl), .twr(cfg_twr), .burst(cfg_burst),
    .load_val(load_val)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wpg_bank_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst(rst),
      .wr_hit(cmd_wr && cmd_bank == BANK_W'(b)),
      .load_val(load_val),
      .pre_ok(pre_ok[b])
    );
  end

  logic early;
  assign early = cmd_pre && !pre_ok[cmd_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_err      <= 1'b0;
      pre_err_bank <= '0;
    end else begin
      pre_err <= early;
      if (early) pre_err_bank <= cmd_bank;
    end
  end

  // R1: reset leaves every bank open and no error
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) && !rst |-> (&pre_ok) && !pre_err);

  // R5: an error pulse only follows an early PRECHARGE
  a_r5_err_cause: assert property (@(posedge clk) disable iff (rst)
    pre_err |-> $past(cmd_pre && !pre_ok[cmd_bank]));

  // R6: no PRECHARGE means no error next cycle
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    !cmd_pre |=> !pre_err);
endmodule

// File: tb/tb_wr_pre_guard.sv
module tb_wr_pre_guard;
  localparam int NB = 8;
  logic clk = 0, rst = 1;
  logic cmd_wr = 0, cmd_pre = 0;
  logic [2:0] cmd_bank = 0;
  logic [4:0] cfg_al = 0, cfg_cwl = 5, cfg_twr = 5;
  logic [1:0] cfg_burst = 0;
  logic [NB-1:0] pre_ok;
  logic pre_err;
  logic [2:0] pre_err_bank;

  always #2.5 clk = ~clk;

  wr_pre_guard dut (.clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_bank(cmd_bank), .cfg_al(cfg_al), .cfg_cwl(cfg_cwl), .cfg_twr(cfg_twr),
    .cfg_burst(cfg_burst), .pre_ok(pre_ok), .pre_err(pre_err),
    .pre_err_bank(pre_err_bank));

  int total = 0, fails = 0, cyc = 0;
  int dl [NB];
  logic exp_err = 0;
  int exp_bank = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic int need();
    return int'(cfg_al) + int'(cfg_cwl) + int'(cfg_twr) + ((cfg_burst == 2'b10) ? 2 : 4);
  endfunction

  // one cycle: check outputs, drive command, advance
  task automatic step(input bit wr, input bit pre, input int bank);
    logic [NB-1:0] e;
    for (int b = 0; b < NB; b++) e[b] = (cyc >= dl[b]);
    check(pre_ok == e, "R4/R8", int'(pre_ok), int'(e));
    if (exp_err) begin
      check(pre_err === 1'b1, "R5", int'(pre_err), 1);
      check(int'(pre_err_bank) == exp_bank, "R5", int'(pre_err_bank), exp_bank);
    end else
      check(pre_err === 1'b0, "R6", int'(pre_err), 0);
    cmd_wr = wr; cmd_pre = pre; cmd_bank = 3'(bank);
    exp_err = pre && (cyc < dl[bank]);
    exp_bank = bank;
    if (wr && cyc + need() > dl[bank]) dl[bank] = cyc + need();
    @(posedge clk); @(negedge clk);
    cmd_wr = 0; cmd_pre = 0;
    cyc++;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) dl[b] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1
    check(pre_ok == '1, "R1", int'(pre_ok), 8'hff);
    check(pre_err == 0, "R1", int'(pre_err), 0);

    // R2/R3 sweep: PRECHARGE one cycle early (R5) and exactly on time (R6)
    for (int bm = 0; bm < 4; bm++)
      for (int al = 0; al < 3; al++)
        for (int cw = 5; cw < 8; cw++)
          for (int tw = 1; tw < 4; tw++) begin
            int bk;
            bk = (bm * 27 + al * 9 + cw * 3 + tw) % NB;
            cfg_burst = 2'(bm); cfg_al = 5'(al); cfg_cwl = 5'(cw); cfg_twr = 5'(tw);
            step(1, 0, bk);
            while (cyc < dl[bk] - 1) step(0, 0, 0);
            step(0, 1, bk);        // early: R5, R10
            step(0, 1, bk);        // on the deadline: R2/R3, R6
            step(0, 0, 0);
          end

    // R7: long write then short rewrite keeps the later deadline
    cfg_burst = 0; cfg_al = 3; cfg_cwl = 8; cfg_twr = 10;
    step(1, 0, 2);
    cfg_al = 0; cfg_cwl = 5; cfg_twr = 1; cfg_burst = 2'b10;
    step(1, 0, 2);
    step(1, 0, 5);
    // R7: extending rewrite while running; R9: config change mid-wait
    cfg_burst = 0; cfg_al = 4; cfg_cwl = 9; cfg_twr = 12;
    repeat (5) step(0, 0, 0);
    step(1, 0, 5);
    cfg_al = 0; cfg_cwl = 0; cfg_twr = 0;
    // R10: early precharges on other banks during the wait
    step(0, 1, 2);
    step(0, 1, 5);
    while (cyc < dl[5] + 2) step(0, 0, 0);
    step(0, 1, 5);
    // all banks back-to-back (R8)
    cfg_al = 1; cfg_cwl = 6; cfg_twr = 2;
    for (int b = 0; b < NB; b++) begin
      cfg_burst = (b % 2) ? 2'b10 : 2'b00;
      step(1, 0, b);
    end
    repeat (20) step(0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule